// File: doc/BRIEF.md
# Register Bank Peripheral with Wait States and Error Response

This block is a peripheral-bus target that holds sixteen data-width registers inside an address window. The window is set by a base-address parameter and a mask parameter: the target answers only while its select input is high and the masked address equals the base. Inside the window, the word offset picks the register. Writes store data and reads return the stored value.

Every access phase is stretched by a parameterised number of wait states before the ready output rises. An error response is raised for a register index past the end of the bank, and for a write that carries the all-ones value. An errored transfer still completes.

Side outputs expose the whole bank as one flat vector. They also give a one-cycle write strobe and the 4-bit index of the register being written, so nearby logic can react to updates.

Top module: `apb_regbank_target`

## Requirements
- R1: While `sel_i` is low, or the address masked by `WIN_MASK` differs from `WIN_BASE`, the target keeps `rdata_o` at zero, `ready_o` low and `err_o` low, and no register changes.
- R2: The register index is the in-window offset divided by the word size in bytes. With 32-bit data, address bits [1:0] are ignored, so offset 0x6 selects register 1.
- R3: A write (`write_i` high) stores `wdata_i` into the indexed register at the clock edge that ends the completing access cycle. The stored value appears on `reg_bank_o` at bits [i*DATA_W +: DATA_W] from then on.
- R4: For a read, `rdata_o` already carries the indexed register in the setup cycle (`sel_i` high, `enable_i` low), and still carries it in the completing access cycle.
- R5: `ready_o` stays low for `WAIT_CYC` access cycles (`sel_i` and `enable_i` high) and rises in access cycle `WAIT_CYC`+1. With `WAIT_CYC` = 0 it is high in the first access cycle.
- R6: The wait counter clears when the target is deselected, or when `enable_i` drops, or when a transfer completes. A transfer that follows an abandoned access therefore waits the full `WAIT_CYC` cycles again.
- R7: An index of 16 or more raises `err_o` in the completing cycle. A read at such an index returns zero in both phases.
- R8: A write of all ones raises `err_o` in the completing cycle and leaves the register unchanged.
- R9: An errored transfer still completes: `ready_o` rises after the same number of wait states as an error-free one.
- R10: `reg_wr_en_o` is high only in the completing cycle of an error-free write, and in that cycle `reg_wr_idx_o` holds that write's 4-bit index. An errored write gives no strobe.
- R11: After an asynchronous reset (`rst_n` low), every register is zero and `ready_o`, `err_o` and `reg_wr_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Target select from the bus |
| enable_i | input | 1 | Access-phase flag |
| addr_i | input | ADDR_W | Byte address |
| write_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, zero when not addressed |
| ready_o | output | 1 | Transfer completes in this cycle |
| err_o | output | 1 | Error response for the completing transfer |
| reg_bank_o | output | NREG*DATA_W | All registers, register i at [i*DATA_W +: DATA_W] |
| reg_wr_en_o | output | 1 | Strobe for an accepted write |
| reg_wr_idx_o | output | 4 | Index of the accepted write |

## Verification
Read data, ready, error and the write strobe are combinational from the bus inputs and the wait counter. They are sampled one time unit after each falling-edge drive, inside the same cycle. Ready is due exactly `WAIT_CYC` access cycles after the setup cycle, and the bench counts the low cycles before it to check this. A stored value is due on the register vector after the rising edge that ends the completing cycle, so the bench checks the bank only after the bus has returned to idle. Read data is sampled once in setup and again at completion.

// File: rtl/apb_regbank_target.sv
module apb_regbank_target #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NREG = 16,
  parameter int WAIT_CYC = 3,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] WIN_MASK = 32'hFFFF_F000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel_i,
  input  logic                   enable_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   write_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   ready_o,
  output logic                   err_o,
  output logic [NREG*DATA_W-1:0] reg_bank_o,
  output logic                   reg_wr_en_o,
  output logic [3:0]             reg_wr_idx_o
);
  localparam int ALIGN = $clog2(DATA_W / 8);
  localparam int IDX_W = $clog2(NREG);
  localparam int CNT_W = (WAIT_CYC > 0) ? $clog2(WAIT_CYC + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WAIT_CYC);
  localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(NREG);

  logic [DATA_W-1:0] regs [NREG];
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] word_off;
  logic [IDX_W-1:0]  idx;
  logic              hit, in_access, bad_idx, bad_data, fault, wr_ok;

  assign hit       = sel_i && ((addr_i & WIN_MASK) == WIN_BASE);
  assign word_off  = (addr_i & ~WIN_MASK) >> ALIGN;
  assign idx       = word_off[IDX_W-1:0];
  assign bad_idx   = word_off >= NREG_A;
  assign bad_data  = write_i && (wdata_i == {DATA_W{1'b1}});
  assign in_access = hit && enable_i;
  assign ready_o   = in_access && (cnt == CNT_MAX);
  assign fault     = bad_idx || bad_data;
  assign err_o     = ready_o && fault;
  assign wr_ok     = ready_o && write_i && !fault;

  assign rdata_o      = (hit && !bad_idx) ? regs[idx] : '0;
  assign reg_wr_en_o  = wr_ok;
  assign reg_wr_idx_o = 4'(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!in_access || ready_o)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_ok && (idx == IDX_W'(g)))
        regs[g] <= wdata_i;
    end
    assign reg_bank_o[g*DATA_W +: DATA_W] = regs[g];
  end

  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (rdata_o == '0 && !ready_o && !err_o && !reg_wr_en_o)); // R1
  AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ready_o); // R9
  AST_NO_STROBE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !reg_wr_en_o); // R10
  AST_READY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (sel_i && enable_i)); // R5
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en_o |=> (regs[$past(idx)] == $past(wdata_i))); // R3
  AST_BAD_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && bad_idx) |-> (rdata_o == '0)); // R7
endmodule

// File: tb/tb_apb_regbank_target.sv
module tb_apb_regbank_target;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NR = 16;
  localparam int NV = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, sel_z = 1'b0, en = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, rdata_z;
  logic ready, ready_z, err, err_z, wen, wen_z;
  logic [3:0] widx, widx_z;
  logic [NR*DW-1:0] bank, bank_z;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  apb_regbank_target dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .enable_i(en), .addr_i(addr),
    .write_i(wr), .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready),
    .err_o(err), .reg_bank_o(bank), .reg_wr_en_o(wen), .reg_wr_idx_o(widx));

  apb_regbank_target #(.WAIT_CYC(0)) dut_z (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_z), .enable_i(en), .addr_i(addr),
    .write_i(wr), .wdata_i(wdata), .rdata_o(rdata_z), .ready_o(ready_z),
    .err_o(err_z), .reg_bank_o(bank_z), .reg_wr_en_o(wen_z), .reg_wr_idx_o(widx_z));

  localparam logic       V_WR  [NV] = '{1, 1, 1, 0, 0, 0, 1, 0, 1, 0, 0};
  localparam logic [31:0] V_AD [NV] = '{32'h1000, 32'h1004, 32'h103C, 32'h1000, 32'h1004,
                                        32'h103C, 32'h1008, 32'h1008, 32'h1040, 32'h1040, 32'h1006};
  localparam logic [31:0] V_DA [NV] = '{32'hDEADBEEF, 32'h12345678, 32'hA5A5A5A5, 0, 0, 0,
                                        32'hFFFFFFFF, 0, 32'h11111111, 0, 0};
  localparam logic [31:0] V_EX [NV] = '{0, 0, 0, 32'hDEADBEEF, 32'h12345678, 32'hA5A5A5A5,
                                        0, 0, 0, 0, 32'h12345678};
  localparam logic       V_ER  [NV] = '{0, 0, 0, 0, 0, 0, 1, 0, 1, 1, 0};

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit to_z, input logic [AW-1:0] a, input bit w, input logic [DW-1:0] d,
                      output logic [DW-1:0] rd_setup, output logic [DW-1:0] rd,
                      output bit e, output int waits, output bit stb, output logic [3:0] si);
    @(negedge clk);
    sel = !to_z; sel_z = to_z; en = 1'b0; addr = a; wr = w; wdata = d;
    #1 rd_setup = to_z ? rdata_z : rdata;
    @(negedge clk);
    en = 1'b1; waits = 0;
    forever begin
      #1;
      if ((to_z ? ready_z : ready) || waits > 20) break;
      waits++;
      @(negedge clk);
    end
    rd = to_z ? rdata_z : rdata;
    e = to_z ? err_z : err;
    stb = to_z ? wen_z : wen;
    si = to_z ? widx_z : widx;
    @(negedge clk);
    sel = 1'b0; sel_z = 1'b0; en = 1'b0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hang expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rs, rd;
    bit e, stb;
    int waits;
    logic [3:0] si;

    repeat (3) @(negedge clk);
    #1;
    chk(bank == '0, "R11 bank zero", bank[63:0], 0);
    chk(!ready && !err && !wen, "R11 outputs low", {ready, err, wen}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      xfer(0, V_AD[i], V_WR[i], V_DA[i], rs, rd, e, waits, stb, si);
      chk(waits == 3, $sformatf("R5 R9 waits v%0d", i), waits, 3);
      chk(e == V_ER[i], $sformatf("R7 R8 err v%0d", i), e, V_ER[i]);
      if (V_WR[i]) begin
        chk(stb == !V_ER[i], $sformatf("R10 strobe v%0d", i), stb, !V_ER[i]);
        if (!V_ER[i])
          chk(si == V_AD[i][5:2], $sformatf("R10 R2 index v%0d", i), si, V_AD[i][5:2]);
      end else begin
        chk(rs == V_EX[i], $sformatf("R4 setup data v%0d", i), rs, V_EX[i]);
        chk(rd == V_EX[i], $sformatf("R4 R2 access data v%0d", i), rd, V_EX[i]);
      end
    end

    @(negedge clk); #1;
    chk(bank[0*DW +: DW] == 32'hDEADBEEF, "R3 bank reg0", bank[0*DW +: DW], 32'hDEADBEEF);
    chk(bank[15*DW +: DW] == 32'hA5A5A5A5, "R3 bank reg15", bank[15*DW +: DW], 32'hA5A5A5A5);
    chk(bank[2*DW +: DW] == 0, "R8 reg2 unchanged", bank[2*DW +: DW], 0);

    @(negedge clk);
    sel = 1'b1; en = 1'b0; addr = 32'h2000; wr = 1'b1; wdata = 32'h5555_5555;
    @(negedge clk); en = 1'b1;
    for (int k = 0; k < 6; k++) begin
      #1 chk(!ready && !err && rdata == 0 && !wen, "R1 outside window", {ready, err, rdata}, 0);
      @(negedge clk);
    end
    sel = 1'b0; addr = 32'h1000;
    #1 chk(rdata == 0 && !ready, "R1 select low", rdata, 0);
    @(negedge clk); en = 1'b0;
    #1 chk(bank[0*DW +: DW] == 32'hDEADBEEF, "R1 no register change", bank[0*DW +: DW], 32'hDEADBEEF);

    @(negedge clk);
    sel = 1'b1; en = 1'b0; addr = 32'h1004; wr = 1'b0;
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    sel = 1'b0; en = 1'b0;
    xfer(0, 32'h1004, 0, 0, rs, rd, e, waits, stb, si);
    chk(waits == 3, "R6 counter cleared after abandon", waits, 3);
    chk(rd == 32'h12345678, "R6 read after abandon", rd, 32'h12345678);

    xfer(1, 32'h1010, 1, 32'hCAFE0001, rs, rd, e, waits, stb, si);
    chk(waits == 0, "R5 zero wait write", waits, 0);
    chk(stb && si == 4, "R10 zero wait strobe", {stb, si}, {1'b1, 4'd4});
    xfer(1, 32'h1010, 0, 0, rs, rd, e, waits, stb, si);
    chk(waits == 0 && rd == 32'hCAFE0001, "R3 R5 zero wait read", rd, 32'hCAFE0001);
    chk(bank[4*DW +: DW] == 0, "R1 other target untouched", bank[4*DW +: DW], 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule